// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Switchable Output Drive

This block is the interrupt front end of one serial channel. It gathers four kinds of cause from the channel: a line error or break, received data or a receive timeout, an empty transmit holding register, and a modem-line change. A four-bit enable register selects which kinds may raise an interrupt. Of everything that is both pending and enabled, only the single most urgent cause is shown to software, as a three-bit identifier plus a separate "nothing pending" flag. Less urgent causes stay hidden until the more urgent one goes away.

Three of the four causes are plain levels held by the receiver, line and modem logic outside this block. The transmit-empty cause is latched here. It is armed out of reset, so the channel asks for service as soon as it leaves reset. It is re-armed when the holding register becomes empty, or when its enable is switched on while the register is empty. It is dropped when the holding register is written, or when software reads the identifier while transmit-empty is the cause on show.

The interrupt line has a value and a separate drive enable, for an external three-state pad. A board-level select pin chooses who owns the enable. When the pin is low, a modem-control bit switches the drive on and off. When the pin is high, the line is driven all the time.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the enable register holds 4'b0010 and transmit-empty is pending, so intId reads 3'b001, noIntPending reads 0 and irqLevel reads 1 without any stimulus.
- R2: Enable bit 0 gates received data and timeout, bit 1 gates transmit-empty, bit 2 gates line status, and bit 3 gates modem status. A cause whose bit is clear is never reported. The enable register loads ierData on a clock edge where ierWe is high.
- R3: Among enabled pending causes, the order from most to least urgent is line status (code 3'b011), receive (3'b010 or 3'b110), transmit-empty (3'b001), then modem status (3'b000). Only the most urgent one appears on intId.
- R4: Received data (3'b010) and receive timeout (3'b110) share one urgency level. When both are present, the data code is shown.
- R5: With nothing enabled and pending, noIntPending is 1 and intId is 3'b000. irqLevel is 1 exactly when noIntPending is 0.
- R6: An idRead pulse while intId shows 3'b001 clears transmit-empty at that clock edge. An idRead while a more urgent cause is shown leaves transmit-empty pending, and it surfaces once that cause drops.
- R7: A thrWrite pulse clears transmit-empty at that clock edge, and this wins over any arming in the same cycle. A low-to-high change of thrEmpty arms transmit-empty at the next edge.
- R8: With selPin low, irqOutEn equals mcrIrqEn.
- R9: With selPin high, irqOutEn is 1 whatever mcrIrqEn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ierWe | input | 1 | Load strobe for the enable register |
| ierData | input | 4 | New enable register value |
| idRead | input | 1 | Software read of the identifier, one-cycle pulse |
| thrWrite | input | 1 | Write to the transmit holding register, one-cycle pulse |
| lineEvt | input | 1 | Line status condition pending (level) |
| rxReady | input | 1 | Receive data at trigger level (level) |
| rxTimeout | input | 1 | Receive timeout pending (level) |
| thrEmpty | input | 1 | Transmit holding register is empty (level) |
| modemEvt | input | 1 | Modem status change pending (level) |
| mcrIrqEn | input | 1 | Modem-control bit that gates the output drive |
| selPin | input | 1 | High: always drive; low: mcrIrqEn decides |
| intId | output | 3 | Code of the most urgent pending cause |
| noIntPending | output | 1 | 1 when no enabled cause is pending |
| irqLevel | output | 1 | Interrupt line value |
| irqOutEn | output | 1 | Drive enable for the three-state pad |

## Verification
Directed steps put several causes up at once and remove them one at a time. This separates a wrong urgency order from a wrong code, and shows the data code winning over the timeout code. Enable patterns that leave single bits set confirm that each mask bit gates its own cause and no other. Reads of the identifier, with transmit-empty both on show and hidden behind a line error, tell a correct conditional clear apart from an unconditional one. Seeded random cycles then mix all inputs, including same-cycle write and arm, against a bench model of the pending latch.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int EN_W = 4;
  localparam int ID_W = 3;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  localparam logic [EN_W-1:0] IER_RESET = 4'b0010;

  typedef enum logic [ID_W-1:0] {
    ID_MODEM = 3'b000,
    ID_TXE   = 3'b001,
    ID_RXD   = 3'b010,
    ID_LINE  = 3'b011,
    ID_TMO   = 3'b110
  } irqId_e;

  typedef struct packed {
    logic ierLoad;
    logic txSet;
    logic txClrWr;
    logic txClrRd;
  } ctrlStrb_t;
endpackage

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int WIDTH = EN_W,
  parameter logic [WIDTH-1:0] RST_VAL = IER_RESET
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [WIDTH-1:0] ierData,
  input  logic             thrEmpty,
  output logic [WIDTH-1:0] ierQ,
  output logic             txPendQ,
  output logic             thrRise
);
  logic thrEmptyQ;

  // Enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ierQ <= RST_VAL;
    else if (strb.ierLoad) ierQ <= ierData;
  end

  // Holding-register-empty history, reset as empty so no spurious edge appears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thrEmptyQ <= 1'b1;
    else thrEmptyQ <= thrEmpty;
  end

  assign thrRise = thrEmpty & ~thrEmptyQ;

  // Transmit-empty pending latch: write clear > arm > read clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txPendQ <= 1'b1;
    else if (strb.txClrWr) txPendQ <= 1'b0;
    else if (strb.txSet) txPendQ <= 1'b1;
    else if (strb.txClrRd) txPendQ <= 1'b0;
  end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int WIDTH = EN_W
) (
  input  logic             ierWe,
  input  logic             ierTxNew,
  input  logic [WIDTH-1:0] ierQ,
  input  logic             txPendQ,
  input  logic             thrRise,
  input  logic             thrEmpty,
  input  logic             idRead,
  input  logic             thrWrite,
  input  logic             lineEvt,
  input  logic             rxReady,
  input  logic             rxTimeout,
  input  logic             modemEvt,
  input  logic             mcrIrqEn,
  input  logic             selPin,
  output ctrlStrb_t        strb,
  output logic [ID_W-1:0]  intId,
  output logic             noIntPending,
  output logic             irqLevel,
  output logic             irqOutEn
);
  logic lsAct, rxdAct, tmoAct, txAct, msAct;
  irqId_e curId;
  logic   noneAct;

  assign lsAct  = lineEvt   & ierQ[EN_LS];
  assign rxdAct = rxReady   & ierQ[EN_RX];
  assign tmoAct = rxTimeout & ierQ[EN_RX];
  assign txAct  = txPendQ   & ierQ[EN_TX];
  assign msAct  = modemEvt  & ierQ[EN_MS];

  // Fixed-order priority pick
  always_comb begin
    noneAct = 1'b0;
    if (lsAct)       curId = ID_LINE;
    else if (rxdAct) curId = ID_RXD;
    else if (tmoAct) curId = ID_TMO;
    else if (txAct)  curId = ID_TXE;
    else if (msAct)  curId = ID_MODEM;
    else begin
      curId   = ID_MODEM;
      noneAct = 1'b1;
    end
  end

  always_comb begin
    strb.ierLoad = ierWe;
    strb.txClrWr = thrWrite;
    strb.txClrRd = idRead & ~noneAct & (curId == ID_TXE);
    strb.txSet   = thrRise | (ierWe & ierTxNew & ~ierQ[EN_TX] & thrEmpty);
  end

  assign intId        = curId;
  assign noIntPending = noneAct;
  assign irqLevel     = ~noneAct;
  assign irqOutEn     = selPin | mcrIrqEn;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uirq_pkg::*;
#(
  parameter int WIDTH = EN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWe,
  input  logic [WIDTH-1:0] ierData,
  input  logic             idRead,
  input  logic             thrWrite,
  input  logic             lineEvt,
  input  logic             rxReady,
  input  logic             rxTimeout,
  input  logic             thrEmpty,
  input  logic             modemEvt,
  input  logic             mcrIrqEn,
  input  logic             selPin,
  output logic [ID_W-1:0]  intId,
  output logic             noIntPending,
  output logic             irqLevel,
  output logic             irqOutEn
);
  ctrlStrb_t        strb;
  logic [WIDTH-1:0] ierQ;
  logic             txPendQ;
  logic             thrRise;

  uirq_datapath #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ierData  (ierData),
    .thrEmpty (thrEmpty),
    .ierQ     (ierQ),
    .txPendQ  (txPendQ),
    .thrRise  (thrRise)
  );

  uirq_ctrl #(.WIDTH(WIDTH)) uCtl (
    .ierWe        (ierWe),
    .ierTxNew     (ierData[EN_TX]),
    .ierQ         (ierQ),
    .txPendQ      (txPendQ),
    .thrRise      (thrRise),
    .thrEmpty     (thrEmpty),
    .idRead       (idRead),
    .thrWrite     (thrWrite),
    .lineEvt      (lineEvt),
    .rxReady      (rxReady),
    .rxTimeout    (rxTimeout),
    .modemEvt     (modemEvt),
    .mcrIrqEn     (mcrIrqEn),
    .selPin       (selPin),
    .strb         (strb),
    .intId        (intId),
    .noIntPending (noIntPending),
    .irqLevel     (irqLevel),
    .irqOutEn     (irqOutEn)
  );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
#(
  parameter int WIDTH = EN_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] ierQ,
  input logic             txPendQ,
  input logic             txSet,
  input logic             idRead,
  input logic             thrWrite,
  input logic             lineEvt,
  input logic             rxReady,
  input logic             mcrIrqEn,
  input logic             selPin,
  input logic [ID_W-1:0]  intId,
  input logic             noIntPending,
  input logic             irqOutEn
);
  assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lineEvt && ierQ[EN_LS]) |-> (!noIntPending && intId == ID_LINE));

  assert_rxd_shown_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && ierQ[EN_RX] && !(lineEvt && ierQ[EN_LS])) |-> (intId == ID_RXD));

  assert_idle_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    noIntPending |-> !(txPendQ && ierQ[EN_TX]));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idRead && !noIntPending && intId == ID_TXE && !thrWrite && !txSet) |=> !txPendQ);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !txPendQ);

  assert_mcr_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !selPin |-> (irqOutEn == mcrIrqEn));

  assert_always_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    selPin |-> irqOutEn);
endmodule

bind uart_irq_prio uirq_checker #(.WIDTH(WIDTH)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .ierQ         (ierQ),
  .txPendQ      (txPendQ),
  .txSet        (strb.txSet),
  .idRead       (idRead),
  .thrWrite     (thrWrite),
  .lineEvt      (lineEvt),
  .rxReady      (rxReady),
  .mcrIrqEn     (mcrIrqEn),
  .selPin       (selPin),
  .intId        (intId),
  .noIntPending (noIntPending),
  .irqOutEn     (irqOutEn)
);

// File: tb/tb_uart_irq_prio.sv
`timescale 1ns/100ps
module tb_uart_irq_prio;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ierWe = 0, idRead = 0, thrWrite = 0;
  logic [3:0] ierData = 4'b0;
  logic       lineEvt = 0, rxReady = 0, rxTimeout = 0, thrEmpty = 1, modemEvt = 0;
  logic       mcrIrqEn = 0, selPin = 0;
  logic [2:0] intId;
  logic       noIntPending, irqLevel, irqOutEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench model state
  logic [3:0] mIer;
  logic       mTx;
  logic       mPrevThr;

  always #2.5 clk = ~clk;

  uart_irq_prio dut (
    .clk(clk), .rstN(rstN), .ierWe(ierWe), .ierData(ierData), .idRead(idRead),
    .thrWrite(thrWrite), .lineEvt(lineEvt), .rxReady(rxReady), .rxTimeout(rxTimeout),
    .thrEmpty(thrEmpty), .modemEvt(modemEvt), .mcrIrqEn(mcrIrqEn), .selPin(selPin),
    .intId(intId), .noIntPending(noIntPending), .irqLevel(irqLevel), .irqOutEn(irqOutEn)
  );

  function automatic logic [3:0] expOut();
    // returns {noInt, id[2:0]} from the requirements
    if (lineEvt && mIer[2])        return 4'b0011;
    else if (rxReady && mIer[0])   return 4'b0010;
    else if (rxTimeout && mIer[0]) return 4'b0110;
    else if (mTx && mIer[1])       return 4'b0001;
    else if (modemEvt && mIer[3])  return 4'b0000;
    else                           return 4'b1000;
  endfunction

  task automatic checkVal(string tag, logic [3:0] act, logic [3:0] exp, string what);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(string tag);
    logic [3:0] e;
    e = expOut();
    checkVal(tag, {1'b0, intId}, {1'b0, e[2:0]}, "intId");
    checkVal(tag, {3'b0, noIntPending}, {3'b0, e[3]}, "noIntPending");
    checkVal(tag, {3'b0, irqLevel}, {3'b0, ~e[3]}, "irqLevel");
    checkVal(tag, {3'b0, irqOutEn}, {3'b0, selPin | mcrIrqEn}, "irqOutEn");
  endtask

  task automatic updateModel();
    logic [3:0] e;
    logic setEvt, rdClr;
    e = expOut();
    setEvt = (thrEmpty && !mPrevThr) || (ierWe && ierData[1] && !mIer[1] && thrEmpty);
    rdClr  = idRead && (e == 4'b0001);
    if (thrWrite)    mTx = 1'b0;
    else if (setEvt) mTx = 1'b1;
    else if (rdClr)  mTx = 1'b0;
    if (ierWe) mIer = ierData;
    mPrevThr = thrEmpty;
  endtask

  // inputs are set at a falling edge; outputs checked just after, model advanced at rise
  task automatic stepCheck(string tag);
    #1;
    checkOutputs(tag);
    @(posedge clk);
    #0.1;
    updateModel();
    @(negedge clk);
    ierWe = 0; idRead = 0; thrWrite = 0;
  endtask

  task automatic writeIer(logic [3:0] v, string tag);
    ierWe = 1; ierData = v;
    stepCheck(tag);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    mIer = 4'b0010; mTx = 1'b1; mPrevThr = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, transmit-empty already pending
    stepCheck("R1");

    // R6: read while transmit-empty shown clears it
    idRead = 1; stepCheck("R6");
    stepCheck("R6");

    // R2: masking per bit
    writeIer(4'b0000, "R2");
    lineEvt = 1; rxReady = 1; rxTimeout = 1; modemEvt = 1;
    stepCheck("R2");
    writeIer(4'b1000, "R2");
    stepCheck("R2");

    // R3 / R4: priority walk-down
    writeIer(4'b1111, "R3");
    stepCheck("R3");
    lineEvt = 0; stepCheck("R4");
    rxReady = 0; stepCheck("R4");
    writeIer(4'b1110, "R2");
    stepCheck("R2");

    // R7: rising thrEmpty arms, write clears
    thrEmpty = 0; stepCheck("R7");
    thrEmpty = 1; stepCheck("R7");
    stepCheck("R7");
    thrWrite = 1; stepCheck("R7");
    stepCheck("R7");

    // R6: read while line shown leaves transmit-empty pending
    thrEmpty = 0; stepCheck("R6");
    thrEmpty = 1; lineEvt = 1; stepCheck("R6");
    idRead = 1; stepCheck("R6");
    lineEvt = 0; stepCheck("R6");

    // R5: nothing pending
    rxTimeout = 0; modemEvt = 0; thrWrite = 1; stepCheck("R5");
    stepCheck("R5");

    // R8 / R9: output drive selection
    selPin = 0; mcrIrqEn = 0; stepCheck("R8");
    mcrIrqEn = 1; stepCheck("R8");
    selPin = 1; mcrIrqEn = 0; stepCheck("R9");
    mcrIrqEn = 1; stepCheck("R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      lineEvt   = ($urandom % 4) == 0;
      rxReady   = ($urandom % 3) == 0;
      rxTimeout = ($urandom % 3) == 0;
      modemEvt  = ($urandom % 3) == 0;
      thrEmpty  = ($urandom % 2) == 0;
      idRead    = ($urandom % 4) == 0;
      thrWrite  = ($urandom % 6) == 0;
      ierWe     = ($urandom % 8) == 0;
      ierData   = 4'($urandom);
      selPin    = ($urandom % 2) == 0;
      mcrIrqEn  = ($urandom % 2) == 0;
      if (lineEvt && mIer[2]) stepCheck("R3");
      else if ((rxReady || rxTimeout) && mIer[0]) stepCheck("R4");
      else if (mTx && mIer[1]) stepCheck("R7");
      else stepCheck("R5");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule